// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block collects eight interrupt request lines, each of which can be set to
sense a rising edge or a high level. It masks them, picks the lowest-numbered
active line, and drives one interrupt request to the processor. When the
processor acknowledges, the block returns a byte-wide vector: the upper bits
come from a programmed base and the low three bits are the number of the winning
line.

The host programs the block through a byte-wide register port. A command address
accepts the start-of-configuration word. A data address takes, in order, the
vector base, the cascade word and an optional mode word, and then the mask. A
third address holds the per-line trigger selection. Until the configuration
sequence has finished, the interrupt request stays low.

The sequencer has five states.
- `ST_UNINIT` is the state after reset.
- `ST_BASE` waits for the vector base.
- `ST_CASC` waits for the cascade word.
- `ST_MODE` waits for the mode word.
- `ST_READY` is the state in which data writes load the mask.

Its transitions are:
- Restart: any state goes to `ST_BASE` on a start word.
- Take-base: `ST_BASE` goes to `ST_CASC`.
- Take-cascade: `ST_CASC` goes to `ST_MODE` if the mode word was requested, otherwise to `ST_READY`.
- Take-mode: `ST_MODE` goes to `ST_READY`.
- Load-mask: `ST_READY` stays in `ST_READY`.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the sequencer is unconfigured (`ready`=0) and `int_req`=0. A read of address 1 returns 8'hFF, a read of address 2 returns 8'h00, and `cascade_id`=7.
- R2: A write to address 0 with bit 4 set is a start word. It restarts the sequence from any state: the mask becomes 8'h00, `cascade_id` becomes 7, `cpu_mode` becomes 0, every latched edge request is discarded, and `ready` drops.
- R3: After a start word, writes to address 1 are taken in turn as three words. The first is the vector base (bits 7:3 kept). The second is the cascade word (bits 2:0 go to `cascade_id`). The third is the mode word (bit 0 goes to `cpu_mode`), and it is taken only when bit 0 of the start word was 1. `ready` rises after the last word of the sequence.
- R4: With `ready`=1, a write to address 1 loads the mask, where a 1 disables the line. A read of address 1 returns the mask.
- R5: A write to address 2 loads the trigger register in any state, where 1 means level and 0 means edge. A read of address 2 returns exactly the value written.
- R6: A write to address 0 with bit 4 clear changes neither the sequencer state nor the mask.
- R7: An edge-sensed line latches a request on a 0-to-1 change. The request stays pending after the line falls, until that line is acknowledged.
- R8: A level-sensed line requests only while it is high. An acknowledge does not remove its request.
- R9: `int_vector` is {base[7:3], n}, where n is the lowest-numbered line that is pending and unmasked. Line 0 has the highest priority.
- R10: While `ready`=0, `int_req` stays 0 whatever the request lines do.
- R11: A masked line never asserts `int_req`. An edge it latched while masked is served once it is unmasked.
- R12: An acknowledge while `int_req`=0 leaves all state unchanged, and `int_vector` shows {base[7:3], 3'b111}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address: 0 command, 1 data/mask, 2 trigger |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (mask, trigger, else zero) |
| irq_in | input | 8 | Interrupt request lines |
| int_ack | input | 1 | Interrupt acknowledge |
| int_req | output | 1 | Interrupt request to processor |
| int_vector | output | 8 | Vector for the current winner |
| ready | output | 1 | Configuration sequence complete |
| cascade_id | output | 3 | Cascade identity from the cascade word |
| cpu_mode | output | 1 | Mode word bit 0 |

## Verification
The assertions assume the host issues at most one write per cycle. They also assume that an acknowledge is a one-cycle pulse, whose vector is read in the same cycle before the clock edge that retires it. The stimulus keeps to these rules:
- Writes come one per cycle through a single task.
- Acknowledges are raised and dropped between clock edges.
- The request lines change only after an edge, so each sampled vector comes from a settled pattern.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } pic_state_e;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

    // bit positions inside the start word
    localparam int START_SEL_BIT = 4;
    localparam int NEED_MODE_BIT = 0;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(N_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              ready,
    output logic              start_hit,
    output logic [BASE_W-1:0] base_q,
    output logic [IDX_W-1:0]  casc_q,
    output logic              mode_q,
    output logic [N_IRQ-1:0]  mask_q,
    output logic [N_IRQ-1:0]  trig_q
);

    pic_state_e state_q, state_n;
    logic       need_mode_q;
    logic       data_wr;
    logic       trig_wr;

    always_comb begin
        start_hit = host_wr && (host_addr == ADDR_CMD) && host_wdata[START_SEL_BIT];
        data_wr   = host_wr && (host_addr == ADDR_DATA);
        trig_wr   = host_wr && (host_addr == ADDR_TRIG);
    end

    // next-state decision
    always_comb begin
        state_n = state_q;
        if (start_hit) begin
            state_n = ST_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                ST_UNINIT: state_n = ST_UNINIT;
                ST_BASE:   state_n = ST_CASC;
                ST_CASC:   state_n = need_mode_q ? ST_MODE : ST_READY;
                ST_MODE:   state_n = ST_READY;
                ST_READY:  state_n = ST_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_n;
    end

    // configuration registers written by the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_mode_q <= 1'b0;
            base_q      <= '0;
            casc_q      <= '1;
            mode_q      <= 1'b0;
            mask_q      <= '1;
            trig_q      <= '0;
        end else begin
            if (start_hit) begin
                need_mode_q <= host_wdata[NEED_MODE_BIT];
                casc_q      <= '1;
                mode_q      <= 1'b0;
                mask_q      <= '0;
            end else if (data_wr) begin
                unique case (state_q)
                    ST_UNINIT: ;
                    ST_BASE:   base_q <= host_wdata[DATA_W-1:IDX_W];
                    ST_CASC:   casc_q <= host_wdata[IDX_W-1:0];
                    ST_MODE:   mode_q <= host_wdata[0];
                    ST_READY:  mask_q <= host_wdata[N_IRQ-1:0];
                endcase
            end
            if (trig_wr) trig_q <= host_wdata[N_IRQ-1:0];
        end
    end

    assign ready = (state_q == ST_READY);

endmodule

// File: rtl/pic_req_detect.sv
module pic_req_detect #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] trig,
    input  logic [N_IRQ-1:0] clr_vec,
    input  logic             flush,
    output logic [N_IRQ-1:0] req_vec
);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic prev_q;
        logic latch_q;
        logic rise;

        assign rise = irq_in[g] & ~prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (flush || trig[g]) latch_q <= 1'b0;
                else                  latch_q <= (latch_q & ~clr_vec[g]) | rise;
            end
        end

        assign req_vec[g] = trig[g] ? irq_in[g] : latch_q;
    end

endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(N_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic [N_IRQ-1:0]  req_vec,
    input  logic [N_IRQ-1:0]  mask,
    input  logic              enable,
    input  logic              ack,
    input  logic [BASE_W-1:0] base,
    output logic              int_req,
    output logic [DATA_W-1:0] vector,
    output logic [N_IRQ-1:0]  clr_vec
);

    logic [N_IRQ-1:0] active;
    logic [IDX_W-1:0] win;

    always_comb begin
        active = req_vec & ~mask & {N_IRQ{enable}};
        win    = '1;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (active[i]) win = IDX_W'(i);
        end
        int_req = |active;
        vector  = {base, win};
        clr_vec = '0;
        if (ack && int_req) clr_vec[win] = 1'b1;
    end

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(N_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              int_ack,
    output logic              int_req,
    output logic [DATA_W-1:0] int_vector,
    output logic              ready,
    output logic [IDX_W-1:0]  cascade_id,
    output logic              cpu_mode
);

    logic              start_hit;
    logic [BASE_W-1:0] base_q;
    logic [N_IRQ-1:0]  mask_q;
    logic [N_IRQ-1:0]  trig_q;
    logic [N_IRQ-1:0]  req_vec;
    logic [N_IRQ-1:0]  clr_vec;

    pic_init_seq #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ready      (ready),
        .start_hit  (start_hit),
        .base_q     (base_q),
        .casc_q     (cascade_id),
        .mode_q     (cpu_mode),
        .mask_q     (mask_q),
        .trig_q     (trig_q)
    );

    pic_req_detect #(.N_IRQ(N_IRQ)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .trig    (trig_q),
        .clr_vec (clr_vec),
        .flush   (start_hit),
        .req_vec (req_vec)
    );

    pic_prio_resolve #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_prio (
        .req_vec (req_vec),
        .mask    (mask_q),
        .enable  (ready),
        .ack     (int_ack),
        .base    (base_q),
        .int_req (int_req),
        .vector  (int_vector),
        .clr_vec (clr_vec)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_DATA: host_rdata[N_IRQ-1:0] = mask_q;
            ADDR_TRIG: host_rdata[N_IRQ-1:0] = trig_q;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(N_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [1:0]        host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [N_IRQ-1:0]  irq_in,
    input logic              int_ack,
    input logic              int_req,
    input logic [DATA_W-1:0] int_vector,
    input logic              ready,
    input logic [BASE_W-1:0] base_q,
    input logic [N_IRQ-1:0]  mask_q,
    input logic [N_IRQ-1:0]  trig_q
);

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd0 && host_wdata[4]) |=> (!ready && mask_q == '0));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && host_wr && host_addr == 2'd1) |=> (mask_q == $past(host_wdata[N_IRQ-1:0])));

    assert_trig_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2) |=> (trig_q == $past(host_wdata[N_IRQ-1:0])));

    assert_level_line0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && trig_q[0] && irq_in[0] && !mask_q[0]) |-> (int_req && int_vector[IDX_W-1:0] == '0));

    assert_vector_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_vector[DATA_W-1:IDX_W] == base_q));

    assert_quiet_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_req);

    assert_winner_unmasked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !mask_q[int_vector[IDX_W-1:0]]);

    assert_spurious_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req) |-> (int_vector[IDX_W-1:0] == '1));

endmodule

bind pic_ctrl pic_ctrl_chk #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .irq_in     (irq_in),
    .int_ack    (int_ack),
    .int_req    (int_req),
    .int_vector (int_vector),
    .ready      (ready),
    .base_q     (base_q),
    .mask_q     (mask_q),
    .trig_q     (trig_q)
);

// File: tb/pic_ctrl_tb.sv
module pic_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [7:0] int_vector;
    logic       ready;
    logic [2:0] cascade_id;
    logic       cpu_mode;

    int checks = 0;
    int errors = 0;

    // bench reference state for the random phase
    bit       model_on = 1'b0;
    bit [7:0] m_latch = 8'h00, m_prev = 8'h00, m_trig = 8'h00, m_mask = 8'h00;
    bit [7:0] m_base = 8'h00;

    always #4 clk = ~clk;

    pic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
        .int_ack(int_ack), .int_req(int_req), .int_vector(int_vector),
        .ready(ready), .cascade_id(cascade_id), .cpu_mode(cpu_mode)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_active(bit [7:0] latch, bit [7:0] lines,
                                            bit [7:0] trig, bit [7:0] mask);
        return ((latch & ~trig) | (lines & trig)) & ~mask;
    endfunction

    function automatic bit [2:0] exp_winner(bit [7:0] act);
        for (int i = 7; i >= 0; i--) if (act[i]) exp_winner = 3'(i);
        if (act == 8'h00) exp_winner = 3'd7;
    endfunction

    task automatic step();
        if (model_on) begin
            bit [7:0] act, clr, rise;
            act  = exp_active(m_latch, irq_in, m_trig, m_mask);
            clr  = (int_ack && act != 0) ? (8'h01 << exp_winner(act)) : 8'h00;
            rise = irq_in & ~m_prev;
            m_latch = ((m_latch & ~clr) | rise) & ~m_trig;
            m_prev  = irq_in;
            if (host_wr && host_addr == 2'd2) m_trig = host_wdata;
            if (host_wr && host_addr == 2'd1) m_mask = host_wdata;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
        #1;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic ack_pulse();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1234_5678));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 ready", ready, 0);
        check("R1 int_req", int_req, 0);
        rd(2'd1, v); check("R1 mask", v, 8'hFF);
        rd(2'd2, v); check("R1 trig", v, 8'h00);
        check("R1 cascade_id", cascade_id, 3'd7);

        // R10 request before configuration
        irq_in = 8'h08; step(); step();
        check("R10 unconfigured", int_req, 0);

        // R2 / R3 full sequence with mode word
        wr(2'd0, 8'h11);
        check("R2 ready drop", ready, 0);
        rd(2'd1, v); check("R2 mask cleared", v, 8'h00);
        check("R2 cascade_id", cascade_id, 3'd7);
        wr(2'd1, 8'h48);
        check("R3 after base", ready, 0);
        wr(2'd1, 8'h02);
        check("R3 mode word pending", ready, 0);
        check("R10 mid sequence", int_req, 0);
        wr(2'd1, 8'h01);
        check("R3 ready", ready, 1);
        check("R3 cascade_id", cascade_id, 3'd2);
        check("R3 cpu_mode", cpu_mode, 1);
        check("R2 latched edge discarded", int_req, 0);

        // R7 / R9 edge latching and priority
        irq_in = 8'h20; step(); irq_in = 8'h00; step();
        check("R7 held after fall", int_req, 1);
        check("R9 vector line5", int_vector, 8'h4D);
        irq_in = 8'h02; step();
        check("R9 line1 wins", int_vector, 8'h49);
        int_ack = 1'b1; #1;
        check("R9 vector on ack", int_vector, 8'h49);
        step(); int_ack = 1'b0; #1;
        check("R7 ack clears line1", int_vector, 8'h4D);
        ack_pulse();
        check("R7 all served", int_req, 0);
        irq_in = 8'h00; step();

        // R4 / R11 masking
        wr(2'd1, 8'h20);
        rd(2'd1, v); check("R4 mask readback", v, 8'h20);
        irq_in = 8'h20; step(); irq_in = 8'h00; step();
        check("R11 masked", int_req, 0);
        wr(2'd1, 8'h00);
        check("R11 served after unmask", int_req, 1);
        check("R11 vector", int_vector, 8'h4D);
        ack_pulse();

        // R5 / R8 level sensing
        wr(2'd2, 8'h80);
        rd(2'd2, v); check("R5 trig readback", v, 8'h80);
        irq_in = 8'h80; #1;
        check("R8 level request", int_req, 1);
        check("R8 vector", int_vector, 8'h4F);
        ack_pulse();
        check("R8 level survives ack", int_req, 1);
        irq_in = 8'h00; #1;
        check("R8 level removed", int_req, 0);

        // R6 command write without start bit
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h0B);
        check("R6 ready kept", ready, 1);
        rd(2'd1, v); check("R6 mask kept", v, 8'h5A);
        wr(2'd1, 8'h00);

        // R12 spurious acknowledge
        int_ack = 1'b1; #1;
        check("R12 spurious vector", int_vector, 8'h4F);
        step(); int_ack = 1'b0; #1;
        rd(2'd1, v); check("R12 mask unchanged", v, 8'h00);
        check("R12 ready unchanged", ready, 1);

        // R2 / R3 restart mid sequence, no mode word
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h30);
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h88);
        check("R2 restart not ready", ready, 0);
        wr(2'd1, 8'h03);
        check("R3 ready without mode", ready, 1);
        check("R3 cascade 3", cascade_id, 3'd3);
        check("R3 cpu_mode cleared", cpu_mode, 0);
        irq_in = 8'h80; #1;
        check("R9 new base", int_vector, 8'h8F);
        irq_in = 8'h00; step();

        // random phase against bench reference
        wr(2'd0, 8'h11); wr(2'd1, 8'hA8); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
        step();
        m_latch = 8'h00; m_prev = 8'h00; m_trig = 8'h80; m_mask = 8'h00; m_base = 8'hA8;
        model_on = 1'b1;
        for (int it = 0; it < 400; it++) begin
            bit [7:0] act;
            if (it % 40 == 0) begin
                wr(2'd2, 8'($urandom));
                wr(2'd1, 8'($urandom) & 8'h3C);
            end
            irq_in  = 8'($urandom);
            int_ack = ($urandom % 4) == 0;
            #1;
            act = exp_active(m_latch, irq_in, m_trig, m_mask);
            check("R7 R8 R11 random req", int_req, act != 0);
            check("R9 R12 random vector", int_vector,
                  (m_base & 8'hF8) | 8'(exp_winner(act)));
            step();
            int_ack = 1'b0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule